// File: doc/BRIEF.md
# Edge Timestamp Capture Channel

This block timestamps transitions of an asynchronous input against a free-running timer count that lives elsewhere on the chip. The raw input first passes through a synchroniser. The channel then watches for the edge polarity chosen by a two-bit select. When that edge appears, it stores the timer value present at that moment and raises a capture flag. A second flag reports that an earlier stored value was overwritten before the first flag was cleared.

The timer can wrap between two edges. To allow for this, the channel counts the timer's update (wrap) pulses between captures and stores that tally in the same clock as the timestamp. A consumer can then form the full elapsed time from a consistent pair of values: the new timestamp minus the old one, plus the stored tally times the timer period. If a wrap pulse and a capture fall on the same clock, the channel decides in hardware which side of the capture the wrap belongs to. It uses the timer value it latched to make that call.

Flag handling is a small four-state machine. The states are FLG_EMPTY (no flags set), FLG_FULL (capture flag only), FLG_OVERRUN (both flags) and FLG_STALE (over-capture flag only). Its transitions are:
- capture: EMPTY to FULL, FULL to OVERRUN, OVERRUN to OVERRUN, STALE to OVERRUN.
- capture together with a clear of the over-capture flag: STALE to FULL.
- clear of the capture flag: FULL to EMPTY, OVERRUN to STALE.
- clear of the over-capture flag: OVERRUN to FULL, STALE to EMPTY.
- both clears: OVERRUN to EMPTY.
- no event: the state holds.

Top module: `edge_stamp_capture`

## Requirements
- R1: The raw input passes through two synchronising flops and an edge-history flop. Take an input change set up before rising clock edge k. Its capture becomes visible on the outputs just after edge k+2, and the outputs have not changed after edge k+1.
- R2: `edge_sel` selects the polarity. 2'b01 captures on rising edges only, 2'b10 on falling edges only, and 2'b11 on both. With 2'b00 no edge captures. An edge of a polarity that is not selected leaves the stored value, the stored tally and the flags unchanged.
- R3: The stored value `cap_value` equals the `cnt_in` present during the clock cycle just before the capture becomes visible. `cap_value` changes on no other event.
- R4: `cap_ovf` receives the number of `upd_pulse` cycles seen since the previous capture, or since reset. The running tally restarts at every capture.
- R5: Suppose `upd_pulse` is high in the capture cycle and the latched `cnt_in` is 0. The wrap is counted before the capture: `cap_ovf` includes it, and the running tally restarts at 0.
- R6: Suppose `upd_pulse` is high in the capture cycle and the latched `cnt_in` is not 0. The wrap is counted after the capture: `cap_ovf` excludes it, and the running tally restarts at 1.
- R7: The running tally saturates at 2^OVF_W-1 (255 by default) and does not wrap.
- R8: A capture sets `cap_flag`, and `clr_cap` clears it one clock later. If a capture and `clr_cap` fall on the same clock, the capture wins and the flag stays set.
- R9: A capture while `cap_flag` is set overwrites `cap_value` and sets `miss_flag`. Only `clr_miss` clears `miss_flag`, independently of `cap_flag`. A clear of the over-capture flag in the same clock as an overwriting capture leaves `miss_flag` set.
- R10: After reset, `cap_value` and `cap_ovf` are zero and both flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_raw | input | 1 | Asynchronous signal to timestamp |
| edge_sel | input | 2 | Polarity select: 01 rising, 10 falling, 11 both, 00 none |
| cnt_in | input | CNT_W | Running timer count |
| upd_pulse | input | 1 | One-clock timer wrap (update) pulse |
| clr_cap | input | 1 | Clears the capture flag |
| clr_miss | input | 1 | Clears the over-capture flag |
| cap_value | output | CNT_W | Timer count stored at the last capture |
| cap_ovf | output | OVF_W | Wrap tally stored with the last capture |
| cap_flag | output | 1 | A capture is waiting to be read |
| miss_flag | output | 1 | A stored capture was overwritten unread |

## Verification
Two functions can fall in the same cycle: the timer wrap and the capture. There is also a second such pair, a flag clear and a capture. The bench provokes each by driving `upd_pulse` or a clear strobe high in exactly the cycle in which the synchronised edge is detected. That cycle is two clocks after the raw change. For the wrap, the latched count is once zero and once non-zero. The outcome is judged from the stored tally of that capture and the tally of the following capture with no wraps in between, and from the flag pair that results.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;

    typedef enum logic [1:0] {
        FLG_EMPTY   = 2'd0,
        FLG_FULL    = 2'd1,
        FLG_OVERRUN = 2'd2,
        FLG_STALE   = 2'd3
    } flag_state_e;

    localparam logic [1:0] SEL_NONE = 2'b00;
    localparam logic [1:0] SEL_RISE = 2'b01;
    localparam logic [1:0] SEL_FALL = 2'b10;
    localparam logic [1:0] SEL_BOTH = 2'b11;

endpackage

// File: rtl/es_edge_sync.sv
module es_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_raw,
    input  logic [1:0] edge_sel,
    output logic       edge_hit
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   hist_q;
    logic                   sync_lvl;
    logic                   rise_seen;
    logic                   fall_seen;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= sig_raw;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[SYNC_STAGES-2:0], sig_raw};
            end
        end
    endgenerate

    assign sync_lvl = chain_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= sync_lvl;
    end

    assign rise_seen = sync_lvl & ~hist_q;
    assign fall_seen = ~sync_lvl & hist_q;
    assign edge_hit  = (edge_sel[0] & rise_seen) | (edge_sel[1] & fall_seen);

endmodule

// File: rtl/es_ovf_tally.sv
module es_ovf_tally #(
    parameter int OVF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_hit,
    input  logic             upd_pulse,
    input  logic             cnt_is_zero,
    output logic [OVF_W-1:0] ovf_latched
);
    localparam logic [OVF_W-1:0] TALLY_MAX = '1;
    localparam logic [OVF_W-1:0] TALLY_ONE = OVF_W'(1);

    logic [OVF_W-1:0] run_q;
    logic [OVF_W-1:0] run_inc;
    logic             wrap_first;

    assign run_inc    = (run_q == TALLY_MAX) ? run_q : run_q + TALLY_ONE;
    assign wrap_first = upd_pulse & cnt_is_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q       <= '0;
            ovf_latched <= '0;
        end else if (edge_hit) begin
            ovf_latched <= wrap_first ? run_inc : run_q;
            run_q       <= (upd_pulse && !cnt_is_zero) ? TALLY_ONE : '0;
        end else if (upd_pulse) begin
            run_q <= run_inc;
        end
    end

endmodule

// File: rtl/es_flag_fsm.sv
module es_flag_fsm
    import edge_stamp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_hit,
    input  logic clr_cap,
    input  logic clr_miss,
    output logic cap_flag,
    output logic miss_flag
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_EMPTY: begin
                if (edge_hit) state_d = FLG_FULL;
            end
            FLG_FULL: begin
                if (edge_hit)     state_d = FLG_OVERRUN;
                else if (clr_cap) state_d = FLG_EMPTY;
            end
            FLG_OVERRUN: begin
                if (edge_hit)                 state_d = FLG_OVERRUN;
                else if (clr_cap && clr_miss) state_d = FLG_EMPTY;
                else if (clr_cap)             state_d = FLG_STALE;
                else if (clr_miss)            state_d = FLG_FULL;
            end
            FLG_STALE: begin
                if (edge_hit)      state_d = clr_miss ? FLG_FULL : FLG_OVERRUN;
                else if (clr_miss) state_d = FLG_EMPTY;
            end
            default: state_d = FLG_EMPTY;
        endcase
    end

    always_comb begin
        cap_flag  = 1'b0;
        miss_flag = 1'b0;
        unique case (state_q)
            FLG_EMPTY:   ;
            FLG_FULL:    cap_flag = 1'b1;
            FLG_OVERRUN: begin
                cap_flag  = 1'b1;
                miss_flag = 1'b1;
            end
            FLG_STALE:   miss_flag = 1'b1;
            default:     ;
        endcase
    end

endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture #(
    parameter int CNT_W       = 16,
    parameter int OVF_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_raw,
    input  logic [1:0]       edge_sel,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             upd_pulse,
    input  logic             clr_cap,
    input  logic             clr_miss,
    output logic [CNT_W-1:0] cap_value,
    output logic [OVF_W-1:0] cap_ovf,
    output logic             cap_flag,
    output logic             miss_flag
);
    logic edge_hit;
    logic cnt_is_zero;

    assign cnt_is_zero = (cnt_in == '0);

    es_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_raw  (sig_raw),
        .edge_sel (edge_sel),
        .edge_hit (edge_hit)
    );

    es_ovf_tally #(.OVF_W(OVF_W)) tally_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_hit    (edge_hit),
        .upd_pulse   (upd_pulse),
        .cnt_is_zero (cnt_is_zero),
        .ovf_latched (cap_ovf)
    );

    es_flag_fsm flags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_hit  (edge_hit),
        .clr_cap   (clr_cap),
        .clr_miss  (clr_miss),
        .cap_flag  (cap_flag),
        .miss_flag (miss_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cap_value <= '0;
        else if (edge_hit) cap_value <= cnt_in;
    end

endmodule

// File: rtl/edge_stamp_capture_chk.sv
module edge_stamp_capture_chk #(
    parameter int CNT_W = 16,
    parameter int OVF_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hit,
    input logic [CNT_W-1:0] cnt_in,
    input logic             clr_cap,
    input logic [CNT_W-1:0] cap_value,
    input logic [OVF_W-1:0] cap_ovf,
    input logic             cap_flag,
    input logic             miss_flag
);
    // R8: a capture always leaves the capture flag set
    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cap_flag);

    // R8: a clear without a capture drops the flag
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && clr_cap) |=> !cap_flag);

    // R3: stored value is the count of the detection cycle
    p_value_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cap_value == $past(cnt_in)));

    // R3, R4: stored pair only moves on a capture
    p_pair_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> ($stable(cap_value) && $stable(cap_ovf)));

    // R9: overwrite of an unread value raises the over-capture flag
    p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cap_flag) |=> miss_flag);

    // R9: the over-capture flag never rises without a capture
    p_miss_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miss_flag) |-> $past(hit));

endmodule

bind edge_stamp_capture edge_stamp_capture_chk #(.CNT_W(CNT_W), .OVF_W(OVF_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (edge_hit),
    .cnt_in    (cnt_in),
    .clr_cap   (clr_cap),
    .cap_value (cap_value),
    .cap_ovf   (cap_ovf),
    .cap_flag  (cap_flag),
    .miss_flag (miss_flag)
);

// File: tb/edge_stamp_capture_tb_top.sv
module edge_stamp_capture_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 16;
    localparam int OVF_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sig_raw = 1'b0;
    logic [1:0]       edge_sel = 2'b01;
    logic [CNT_W-1:0] cnt_in = '0;
    logic             upd_pulse = 1'b0;
    logic             clr_cap = 1'b0;
    logic             clr_miss = 1'b0;
    logic [CNT_W-1:0] cap_value;
    logic [OVF_W-1:0] cap_ovf;
    logic             cap_flag;
    logic             miss_flag;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_stamp_capture #(.CNT_W(CNT_W), .OVF_W(OVF_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_raw   (sig_raw),
        .edge_sel  (edge_sel),
        .cnt_in    (cnt_in),
        .upd_pulse (upd_pulse),
        .clr_cap   (clr_cap),
        .clr_miss  (clr_miss),
        .cap_value (cap_value),
        .cap_ovf   (cap_ovf),
        .cap_flag  (cap_flag),
        .miss_flag (miss_flag)
    );

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", what, got, exp);
        end
    endtask

    task automatic chk_all(input string req, input int val, input int ovf, input bit cf, input bit mf);
        chk({req, " cap_value"}, 32'(cap_value), 32'(val));
        chk({req, " cap_ovf"},   32'(cap_ovf),   32'(ovf));
        chk({req, " cap_flag"},  32'(cap_flag),  32'(cf));
        chk({req, " miss_flag"}, 32'(miss_flag), 32'(mf));
    endtask

    // drive a raw edge; optional wrap pulse and capture-flag clear in the detection cycle
    task automatic stamp(input bit level, input int cnt, input bit upd_at_hit, input bit clr_at_hit);
        @(negedge clk);
        sig_raw = level;
        cnt_in  = CNT_W'(cnt);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        upd_pulse = upd_at_hit;
        clr_cap   = clr_at_hit;
        @(posedge clk);
        @(negedge clk);
        upd_pulse = 1'b0;
        clr_cap   = 1'b0;
    endtask

    task automatic updates(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            upd_pulse = 1'b1;
            @(negedge clk);
            upd_pulse = 1'b0;
        end
    endtask

    task automatic clears(input bit c, input bit m);
        @(negedge clk);
        clr_cap  = c;
        clr_miss = m;
        @(negedge clk);
        clr_cap  = 1'b0;
        clr_miss = 1'b0;
    endtask

    task automatic t_reset();
        chk_all("R10 reset", 0, 0, 1'b0, 1'b0);
    endtask

    task automatic t_rise_latency();
        edge_sel = 2'b01;
        updates(3);
        @(negedge clk);
        sig_raw = 1'b1;
        cnt_in  = 16'd100;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk("R1 no capture after two edges", 32'(cap_flag), 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk_all("R1 R3 R4 rising capture", 100, 3, 1'b1, 1'b0);
        stamp(1'b0, 200, 1'b0, 1'b0);
        chk_all("R2 falling ignored in rise mode", 100, 3, 1'b1, 1'b0);
        clears(1'b1, 1'b0);
        chk("R8 clear capture flag", 32'(cap_flag), 32'd0);
    endtask

    task automatic t_falling();
        edge_sel = 2'b10;
        stamp(1'b1, 300, 1'b0, 1'b0);
        chk_all("R2 rising ignored in fall mode", 100, 3, 1'b0, 1'b0);
        stamp(1'b0, 400, 1'b0, 1'b0);
        chk_all("R2 falling capture", 400, 0, 1'b1, 1'b0);
        clears(1'b1, 1'b0);
    endtask

    task automatic t_both();
        edge_sel = 2'b11;
        updates(1);
        stamp(1'b1, 500, 1'b0, 1'b0);
        chk_all("R2 R4 both mode rising", 500, 1, 1'b1, 1'b0);
        clears(1'b1, 1'b0);
        stamp(1'b0, 600, 1'b0, 1'b0);
        chk_all("R2 R4 both mode falling", 600, 0, 1'b1, 1'b0);
        clears(1'b1, 1'b0);
    endtask

    task automatic t_none();
        edge_sel = 2'b00;
        stamp(1'b1, 700, 1'b0, 1'b0);
        stamp(1'b0, 800, 1'b0, 1'b0);
        chk_all("R2 select none ignores edges", 600, 0, 1'b0, 1'b0);
        edge_sel = 2'b11;
    endtask

    task automatic t_wrap_at_zero();
        updates(2);
        stamp(1'b1, 0, 1'b1, 1'b0);
        chk_all("R5 wrap with zero count counted before", 0, 3, 1'b1, 1'b0);
        clears(1'b1, 1'b0);
        stamp(1'b0, 9, 1'b0, 1'b0);
        chk("R5 tally restarts at 0", 32'(cap_ovf), 32'd0);
        clears(1'b1, 1'b0);
    endtask

    task automatic t_wrap_nonzero();
        updates(2);
        stamp(1'b1, 5, 1'b1, 1'b0);
        chk_all("R6 wrap with nonzero count counted after", 5, 2, 1'b1, 1'b0);
        clears(1'b1, 1'b0);
        stamp(1'b0, 6, 1'b0, 1'b0);
        chk("R6 tally restarts at 1", 32'(cap_ovf), 32'd1);
        clears(1'b1, 1'b0);
    endtask

    task automatic t_overrun();
        stamp(1'b1, 10, 1'b0, 1'b0);
        chk_all("R9 first capture", 10, 0, 1'b1, 1'b0);
        stamp(1'b0, 11, 1'b0, 1'b0);
        chk_all("R9 overwrite raises miss", 11, 0, 1'b1, 1'b1);
        clears(1'b1, 1'b0);
        chk_all("R9 clr_cap keeps miss", 11, 0, 1'b0, 1'b1);
        stamp(1'b1, 12, 1'b0, 1'b0);
        chk_all("R9 capture with stale miss", 12, 0, 1'b1, 1'b1);
        clears(1'b0, 1'b1);
        chk_all("R9 clr_miss keeps cap flag", 12, 0, 1'b1, 1'b0);
        stamp(1'b0, 13, 1'b0, 1'b1);
        chk_all("R8 capture wins over same-cycle clear", 13, 0, 1'b1, 1'b1);
        clears(1'b1, 1'b1);
        chk_all("R9 both clears", 13, 0, 1'b0, 1'b0);
    endtask

    task automatic t_saturate();
        updates(300);
        stamp(1'b1, 14, 1'b0, 1'b0);
        chk("R7 tally saturates", 32'(cap_ovf), 32'd255);
        stamp(1'b0, 15, 1'b0, 1'b0);
        chk("R7 R4 tally restarts after saturation", 32'(cap_ovf), 32'd0);
        clears(1'b1, 1'b1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rise_latency();
        t_falling();
        t_both();
        t_none();
        t_wrap_at_zero();
        t_wrap_nonzero();
        t_overrun();
        t_saturate();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule